// File: doc/BRIEF.md
# Burst Address Sequencer with Selectable Order

This block produces the address for every beat of a four-beat burst in front of a synchronous memory array. A burst begins when either of two active-low address strobes is sampled low on a rising clock edge. The external address is then captured, and the beat counter is cleared. After that first beat, each clock edge with the advance input low moves the burst to its next beat. The upper address bits stay as captured for the whole burst.

The two low bits follow one of two orders, picked by a static mode input. In linear order the start value is incremented modulo four. In interleaved order the start value is XORed with the beat number. Three chip enables are registered whenever a burst is loaded, and they decide whether the burst is selected. Advancing only takes place inside a selected burst.

No data flows through this block, so it has no valid/ready interface. Every pin is a plain control or status signal, sampled or updated on the rising clock edge. Back-pressure does not apply.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted (rst_n low), addr_out is all zeros and burst_sel is 0.
- R2: A controller strobe (ctl_stb_n low at a rising edge) always loads the address. From the next edge onward, addr_out equals the sampled addr_in, whatever the enables are.
- R3: A processor strobe (cpu_stb_n low) loads the address in the same way only when ce1_n is low. When ce1_n is high it is ignored: with adv_n high, addr_out does not change.
- R4: On every load, burst_sel is set to 1 exactly when ce1_n=0, ce2=1 and ce3_n=0. It is set to 0 otherwise. burst_sel keeps its value until the next load.
- R5: With order_lin=1 (linear), the low two bits of addr_out on beat n equal (start low bits + n) mod 4.
- R6: With order_lin=0 (interleaved), the low two bits of addr_out on beat n equal (start low bits XOR n).
- R7: The beat advances by one on an edge only when adv_n is low, no load occurs on that edge, and burst_sel is 1. Otherwise, with no load, addr_out holds its value.
- R8: After the fourth beat, a further advance returns to the start address. The upper bits (all but the low two) never change between loads, so there is no carry from the low bits.
- R9: A load and an advance on the same edge perform the load only, which leaves the burst at beat 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_in | input | ADDR_W (18) | External address, captured on a load |
| cpu_stb_n | input | 1 | Processor-side burst strobe, active low, qualified by ce1_n |
| ctl_stb_n | input | 1 | Controller-side burst strobe, active low, unqualified |
| adv_n | input | 1 | Advance request, active low |
| ce1_n | input | 1 | Chip enable 1, active low |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| order_lin | input | 1 | Burst order: 1 = linear, 0 = interleaved |
| addr_out | output | ADDR_W (18) | Current burst address |
| burst_sel | output | 1 | Enables registered at the last load selected the device |

## Verification
Every result is due one rising edge after its stimulus. addr_out and burst_sel are decoded from registers without any further pipeline stage. The driver applies each stimulus at a falling edge and queues the expected address and select for that cycle. The monitor compares the queue entry 1 ns after the next rising edge, so each check falls in the cycle in which the result first appears. The reset state is checked while reset is still held.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  typedef enum logic {
    ORD_INTERLEAVE = 1'b0,
    ORD_LINEAR     = 1'b1
  } order_e;

  typedef struct packed {
    logic load;
    logic step;
    logic sel_d;
  } seq_ctl_t;
endpackage

// File: rtl/burst_load_ctl.sv
module burst_load_ctl
  import bseq_pkg::*;
(
  input  logic     cpu_stb_n,
  input  logic     ctl_stb_n,
  input  logic     adv_n,
  input  logic     ce1_n,
  input  logic     ce2,
  input  logic     ce3_n,
  input  logic     sel_q,
  output seq_ctl_t ctl
);
  logic cpu_load;
  logic ctl_load;

  always_comb begin
    cpu_load  = ~cpu_stb_n & ~ce1_n;
    ctl_load  = ~ctl_stb_n;
    ctl.load  = cpu_load | ctl_load;
    ctl.step  = ~ctl.load & ~adv_n & sel_q;
    ctl.sel_d = ~ce1_n & ce2 & ~ce3_n;
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  output logic [BEAT_W-1:0] beat_q
);
  localparam logic [BEAT_W-1:0] ONE = {{(BEAT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n)    beat_q <= '0;
    else if (load) beat_q <= '0;
    else if (step) beat_q <= beat_q + ONE;
  end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import bseq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_lo,
  input  logic [BEAT_W-1:0] beat,
  input  order_e            order,
  output logic [BEAT_W-1:0] out_lo
);
  logic [BEAT_W-1:0] lin_lo;
  logic [BEAT_W-1:0] ilv_lo;

  assign lin_lo = start_lo + beat;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
    assign ilv_lo[b] = start_lo[b] ^ beat[b];
  end

  assign out_lo = (order == ORD_LINEAR) ? lin_lo : ilv_lo;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bseq_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              cpu_stb_n,
  input  logic              ctl_stb_n,
  input  logic              adv_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              order_lin,
  output logic [ADDR_W-1:0] addr_out,
  output logic              burst_sel
);
  localparam int UP_W = ADDR_W - BEAT_W;

  seq_ctl_t          ctl;
  logic [ADDR_W-1:0] base_q;
  logic              sel_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] low_addr;
  order_e            order;

  assign order = order_e'(order_lin);

  burst_load_ctl u_ctl (
    .cpu_stb_n (cpu_stb_n),
    .ctl_stb_n (ctl_stb_n),
    .adv_n     (adv_n),
    .ce1_n     (ce1_n),
    .ce2       (ce2),
    .ce3_n     (ce3_n),
    .sel_q     (sel_q),
    .ctl       (ctl)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      sel_q  <= 1'b0;
    end else if (ctl.load) begin
      base_q <= addr_in;
      sel_q  <= ctl.sel_d;
    end
  end

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (ctl.load),
    .step   (ctl.step),
    .beat_q (beat_q)
  );

  burst_order_map #(.BEAT_W(BEAT_W)) u_map (
    .start_lo (base_q[BEAT_W-1:0]),
    .beat     (beat_q),
    .order    (order),
    .out_lo   (low_addr)
  );

  assign addr_out  = {base_q[ADDR_W-1 -: UP_W], low_addr};
  assign burst_sel = sel_q;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 18,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_in,
  input logic              cpu_stb_n,
  input logic              ctl_stb_n,
  input logic              adv_n,
  input logic              ce1_n,
  input logic              ce2,
  input logic              ce3_n,
  input logic              order_lin,
  input logic [ADDR_W-1:0] addr_out,
  input logic              burst_sel,
  input logic [BEAT_W-1:0] beat_q
);
  logic any_load;
  assign any_load = ~ctl_stb_n | (~cpu_stb_n & ~ce1_n);

  assert_ctl_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_stb_n |=> addr_out == $past(addr_in));

  assert_cpu_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_stb_n && ce1_n && ctl_stb_n && adv_n) |=>
      ($stable(addr_out) || order_lin != $past(order_lin)));

  assert_sel_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    any_load |=> burst_sel == $past(!ce1_n && ce2 && !ce3_n));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_load && (adv_n || !burst_sel)) |=>
      ($stable(beat_q) && $stable(burst_sel)));

  assert_upper_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !any_load |=> $stable(addr_out[ADDR_W-1:BEAT_W]));

  assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (any_load && !adv_n) |=> beat_q == '0);
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr_in   (addr_in),
  .cpu_stb_n (cpu_stb_n),
  .ctl_stb_n (ctl_stb_n),
  .adv_n     (adv_n),
  .ce1_n     (ce1_n),
  .ce2       (ce2),
  .ce3_n     (ce3_n),
  .order_lin (order_lin),
  .addr_out  (addr_out),
  .burst_sel (burst_sel),
  .beat_q    (beat_q)
);

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic          cpu_stb_n = 1'b1, ctl_stb_n = 1'b1, adv_n = 1'b1;
  logic          ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1, order_lin = 1'b1;
  logic [AW-1:0] addr_out;
  logic          burst_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [AW-1:0] q_addr[$];
  bit            q_sel[$];
  string         q_tag[$];

  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_beat = '0;
  bit            m_sel  = 0;

  always #2.5 clk = ~clk;

  burst_addr_seq u0 (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .cpu_stb_n(cpu_stb_n),
    .ctl_stb_n(ctl_stb_n), .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2),
    .ce3_n(ce3_n), .order_lin(order_lin), .addr_out(addr_out), .burst_sel(burst_sel)
  );

  task automatic check(string tag, logic [AW-1:0] a, bit s, logic [AW-1:0] ea, bit es);
    checks++;
    if (a !== ea || s !== es) begin
      fails++;
      $display("FAIL %s: addr=%h sel=%0d expected addr=%h sel=%0d", tag, a, s, ea, es);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the reference result.
  task automatic cyc(bit cpu_n, bit ctl_n, bit adv, bit e1_n, bit e2, bit e3_n,
                     bit lin, logic [AW-1:0] a, string tag);
    bit ld;
    logic [1:0] lo;
    @(negedge clk);
    cpu_stb_n = cpu_n; ctl_stb_n = ctl_n; adv_n = adv;
    ce1_n = e1_n; ce2 = e2; ce3_n = e3_n; order_lin = lin; addr_in = a;
    ld = !ctl_n || (!cpu_n && !e1_n);
    if (ld) begin
      m_base = a; m_beat = 2'd0; m_sel = !e1_n && e2 && !e3_n;
    end else if (!adv && m_sel) begin
      m_beat = m_beat + 2'd1;
    end
    lo = lin ? (m_base[1:0] + m_beat) : (m_base[1:0] ^ m_beat);
    q_addr.push_back({m_base[AW-1:2], lo});
    q_sel.push_back(m_sel);
    q_tag.push_back(tag);
  endtask

  // Monitor: compares 1 ns after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_addr.size() > 0)
        check(q_tag.pop_front(), addr_out, burst_sel, q_addr.pop_front(), q_sel.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1 reset", addr_out, burst_sel, '0, 1'b0);
    @(negedge clk) rst_n = 1'b1;

    // R2/R4/R5/R8: controller load, linear advance with wrap, low start 1
    cyc(1,0,1, 0,1,0, 1, 18'h12345, "R2 ctl load");
    cyc(1,1,0, 0,1,0, 1, 18'h00000, "R5 linear beat1");
    cyc(1,1,0, 0,1,0, 1, 18'h00000, "R5 linear beat2");
    cyc(1,1,0, 0,1,0, 1, 18'h00000, "R5 linear beat3");
    cyc(1,1,0, 0,1,0, 1, 18'h00000, "R8 linear wrap");
    cyc(1,1,1, 0,1,0, 1, 18'h3FFFF, "R7 hold no adv");

    // R3/R6: processor load, interleaved from low start 2
    cyc(0,1,1, 0,1,0, 0, 18'h2AAAA, "R3 cpu load");
    cyc(1,1,0, 0,1,0, 0, 18'h0, "R6 ilv beat1");
    cyc(1,1,0, 0,1,0, 0, 18'h0, "R6 ilv beat2");
    cyc(1,1,0, 0,1,0, 0, 18'h0, "R6 ilv beat3");
    cyc(1,1,0, 0,1,0, 0, 18'h0, "R8 ilv wrap");

    // R3: processor strobe with ce1_n high is ignored
    cyc(0,1,1, 1,1,0, 0, 18'h15555, "R3 cpu ignored");

    // R2/R4/R7: controller load with ce1_n high -> deselected, advance ignored
    cyc(1,0,1, 1,1,0, 1, 18'h00101, "R4 ctl load deselect");
    cyc(1,1,0, 1,1,0, 1, 18'h0, "R7 adv while deselected");
    cyc(1,0,1, 0,0,0, 1, 18'h00202, "R4 ce2 low");
    cyc(1,0,1, 0,1,1, 1, 18'h00303, "R4 ce3_n high");

    // R9: load and advance on the same edge
    cyc(1,0,0, 0,1,0, 1, 18'h3FFFF, "R9 load wins");
    cyc(1,1,0, 0,1,0, 1, 18'h0, "R8 no carry upper");
    cyc(0,0,0, 0,1,0, 0, 18'h01236, "R9 both strobes plus adv");
    cyc(1,1,0, 0,1,0, 0, 18'h0, "R6 ilv start2 beat1");
    cyc(1,1,1, 0,1,0, 0, 18'h0, "R7 final hold");

    @(negedge clk);
    cpu_stb_n = 1; ctl_stb_n = 1; adv_n = 1;
    repeat (2) @(posedge clk);
    #2;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule